// File: doc/BRIEF.md
# Packed Integer Media Lane Unit

This block is a combinational 64-bit packed integer datapath for media-style work. An opcode selects one operation. The operation runs across all lanes of two 64-bit vector operands at once. The available operations are:

- a rounding average on 8-bit or 16-bit lanes;
- unsigned maximum and minimum on bytes;
- signed maximum and minimum on 16-bit words;
- collection of the top bit of every byte into a mask;
- reading one 16-bit word out of a vector, chosen by a 2-bit index;
- writing one 16-bit word into a vector, chosen by a 2-bit index.

The unit has two outputs, a 64-bit vector result and a 32-bit scalar result. Each operation drives one of the two, and the other output reads zero. The unit sits inside an execution pipeline, and the surrounding stage registers its outputs.

Byte lane i occupies bits [8i+7:8i] and word lane i occupies bits [16i+15:16i]. Lane 0 is the least significant.

Top module: `mda_media_alu`

## Requirements
- R1: Opcode 0 computes (a+b+1)>>1 on each unsigned 8-bit lane of opa_i and opb_i. The sum carries one extra bit, so 0xFF with 0xFF yields 0xFF.
- R2: Opcode 1 computes (a+b+1)>>1 on each unsigned 16-bit lane. 0xFFFF with 0xFFFF yields 0xFFFF.
- R3: Opcode 2 returns the larger value of each byte lane, read as unsigned. Opcode 3 returns the smaller value.
- R4: Opcode 4 returns the larger value of each 16-bit lane, read as signed two's complement. Opcode 5 returns the smaller value.
- R5: Opcode 6 sets scalar_o bit i to bit 7 of byte lane i of opa_i, for i = 0 to 7. Bits 31:8 of scalar_o are zero.
- R6: Opcode 7 places word lane word_sel_i of opa_i in scalar_o[15:0]. Bits 31:16 of scalar_o are zero.
- R7: Opcode 8 returns opa_i with word lane word_sel_i replaced by scalar_i[15:0]. The other three words are unchanged, and opb_i has no effect.
- R8: vec_o is zero for opcodes 6 and 7. scalar_o is zero for opcodes 0 to 5 and 8.
- R9: Opcodes 9 to 15 drive both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 64 | First vector operand |
| opb_i | input | 64 | Second vector operand |
| scalar_i | input | 32 | Scalar operand; bits 15:0 are the inserted word |
| word_sel_i | input | 2 | Word lane index for extract and insert |
| op_i | input | 4 | Operation code |
| vec_o | output | 64 | Vector result |
| scalar_o | output | 32 | Scalar result |

## Verification
The averages are driven with all-ones lanes, which expose a sum that lacks a carry bit. They are also driven with sums that differ only in parity, which separate round-up from truncation. The max/min operations get operands whose lanes differ only in the top bit, which shows whether each size is compared as signed or unsigned. The mask, extract and insert operations walk every index and use alternating byte signs, so a swapped lane or index appears as a misplaced bit or word. Long streams of pseudo-random operands and opcodes then cover mixed lane patterns and the zero outputs.

// File: rtl/mda_pkg.sv
package mda_pkg;
  typedef enum logic [3:0] {
    OP_AVG_B  = 4'd0,
    OP_AVG_W  = 4'd1,
    OP_MAX_UB = 4'd2,
    OP_MIN_UB = 4'd3,
    OP_MAX_SW = 4'd4,
    OP_MIN_SW = 4'd5,
    OP_MASK_B = 4'd6,
    OP_EXT_W  = 4'd7,
    OP_INS_W  = 4'd8
  } mda_op_e;
endpackage

// File: rtl/mda_lane_avg.sv
module mda_lane_avg #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] avg_o
);
  localparam int NLANE = DATA_W / LANE_W;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [LANE_W:0] sum;
    logic [LANE_W-1:0] la, lb, lr;
    assign la = a_i[i*LANE_W +: LANE_W];
    assign lb = b_i[i*LANE_W +: LANE_W];
    assign sum = {1'b0, la} + {1'b0, lb} + {{LANE_W{1'b0}}, 1'b1};
    assign lr = sum[LANE_W:1];
    assign avg_o[i*LANE_W +: LANE_W] = lr;

    always_comb begin
      if (!$isunknown({la, lb})) begin
        assert_avg_in_range_R1_R2: assert ((lr >= la || lr >= lb) && (lr <= la || lr <= lb))
          else $error("average lane outside its operands");
      end
    end
  end
endmodule

// File: rtl/mda_lane_minmax.sv
module mda_lane_minmax #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter bit SIGNED = 1'b0
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] max_o,
  output logic [DATA_W-1:0] min_o
);
  localparam int NLANE = DATA_W / LANE_W;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [LANE_W-1:0] la, lb, lmax, lmin;
    logic a_gt;
    assign la = a_i[i*LANE_W +: LANE_W];
    assign lb = b_i[i*LANE_W +: LANE_W];
    if (SIGNED) begin : g_s
      assign a_gt = $signed(la) > $signed(lb);
    end else begin : g_u
      assign a_gt = la > lb;
    end
    assign lmax = a_gt ? la : lb;
    assign lmin = a_gt ? lb : la;
    assign max_o[i*LANE_W +: LANE_W] = lmax;
    assign min_o[i*LANE_W +: LANE_W] = lmin;

    always_comb begin
      if (!$isunknown({la, lb})) begin
        assert_minmax_pair_R3_R4: assert ((lmax == la && lmin == lb) || (lmax == lb && lmin == la))
          else $error("max/min lane is not a permutation of operands");
      end
    end
  end
endmodule

// File: rtl/mda_word_access.sv
module mda_word_access #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0]               vec_i,
  input  logic [WORD_W-1:0]               word_i,
  input  logic [$clog2(DATA_W/WORD_W)-1:0] sel_i,
  output logic [WORD_W-1:0]               word_o,
  output logic [DATA_W-1:0]               ins_o,
  output logic [DATA_W/BYTE_W-1:0]        mask_o
);
  localparam int NWORD = DATA_W / WORD_W;
  localparam int NBYTE = DATA_W / BYTE_W;
  localparam int SEL_W = $clog2(NWORD);

  for (genvar b = 0; b < NBYTE; b++) begin : g_mask
    assign mask_o[b] = vec_i[b*BYTE_W + BYTE_W - 1];
  end

  for (genvar w = 0; w < NWORD; w++) begin : g_ins
    assign ins_o[w*WORD_W +: WORD_W] = (sel_i == SEL_W'(w)) ? word_i : vec_i[w*WORD_W +: WORD_W];
  end

  always_comb begin
    word_o = '0;
    for (int w = 0; w < NWORD; w++) begin
      if (sel_i == SEL_W'(w)) word_o = vec_i[w*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    if (!$isunknown({vec_i, word_i, sel_i})) begin
      assert_insert_keeps_others_R7: assert ((ins_o ^ vec_i) == ((vec_i ^ ins_o) & ({{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}} << (sel_i * WORD_W))))
        else $error("insert changed an unselected word");
      assert_extract_roundtrip_R6: assert (((ins_o >> (sel_i * WORD_W)) & {{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}}) == {{(DATA_W-WORD_W){1'b0}}, word_i})
        else $error("inserted word not found at index");
    end
  end
endmodule

// File: rtl/mda_media_alu.sv
module mda_media_alu
  import mda_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int SCALAR_W = 32
) (
  input  logic [DATA_W-1:0]   opa_i,
  input  logic [DATA_W-1:0]   opb_i,
  input  logic [SCALAR_W-1:0] scalar_i,
  input  logic [1:0]          word_sel_i,
  input  logic [3:0]          op_i,
  output logic [DATA_W-1:0]   vec_o,
  output logic [SCALAR_W-1:0] scalar_o
);
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int NBYTE  = DATA_W / BYTE_W;

  logic [DATA_W-1:0] avg_b, avg_w, max_ub, min_ub, max_sw, min_sw, ins_v;
  logic [WORD_W-1:0] ext_w;
  logic [NBYTE-1:0]  mask_b;
  logic              unused_scalar_hi;
  mda_op_e           op;

  assign op = mda_op_e'(op_i);
  assign unused_scalar_hi = ^scalar_i[SCALAR_W-1:WORD_W];

  mda_lane_avg #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_avg_b (.a_i(opa_i), .b_i(opb_i), .avg_o(avg_b));
  mda_lane_avg #(.DATA_W(DATA_W), .LANE_W(WORD_W)) u_avg_w (.a_i(opa_i), .b_i(opb_i), .avg_o(avg_w));

  mda_lane_minmax #(.DATA_W(DATA_W), .LANE_W(BYTE_W), .SIGNED(1'b0)) u_mm_b (
    .a_i(opa_i), .b_i(opb_i), .max_o(max_ub), .min_o(min_ub));
  mda_lane_minmax #(.DATA_W(DATA_W), .LANE_W(WORD_W), .SIGNED(1'b1)) u_mm_w (
    .a_i(opa_i), .b_i(opb_i), .max_o(max_sw), .min_o(min_sw));

  mda_word_access #(.DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_word (
    .vec_i(opa_i), .word_i(scalar_i[WORD_W-1:0]), .sel_i(word_sel_i),
    .word_o(ext_w), .ins_o(ins_v), .mask_o(mask_b));

  always_comb begin
    vec_o    = '0;
    scalar_o = '0;
    case (op)
      OP_AVG_B:  vec_o = avg_b;
      OP_AVG_W:  vec_o = avg_w;
      OP_MAX_UB: vec_o = max_ub;
      OP_MIN_UB: vec_o = min_ub;
      OP_MAX_SW: vec_o = max_sw;
      OP_MIN_SW: vec_o = min_sw;
      OP_MASK_B: scalar_o = {{(SCALAR_W-NBYTE){1'b0}}, mask_b};
      OP_EXT_W:  scalar_o = {{(SCALAR_W-WORD_W){1'b0}}, ext_w};
      OP_INS_W:  vec_o = ins_v;
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, vec_o, scalar_o})) begin
      assert_one_output_R8: assert (vec_o == '0 || scalar_o == '0)
        else $error("both outputs nonzero");
      assert_unused_op_zero_R9: assert (op_i <= 4'd8 || (vec_o == '0 && scalar_o == '0))
        else $error("unused opcode produced data");
      assert_mask_hi_zero_R5: assert (op_i != 4'd6 || scalar_o[SCALAR_W-1:NBYTE] == '0)
        else $error("mask upper bits set");
    end
  end
endmodule

// File: tb/mda_media_alu_tb.sv
module mda_media_alu_tb;
  logic clk;
  logic rst_n;
  logic [63:0] opa, opb;
  logic [31:0] sc;
  logic [1:0]  sel;
  logic [3:0]  op;
  logic [63:0] vec;
  logic [31:0] sco;
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  mda_media_alu u_dut (.opa_i(opa), .opb_i(opb), .scalar_i(sc), .word_sel_i(sel),
                       .op_i(op), .vec_o(vec), .scalar_o(sco));

  initial clk = 0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog expired: actual cycles=%0d expected done", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      default: return "R9";
    endcase
  endfunction

  // behavioural reference: returns {scalar, vector}
  function automatic logic [95:0] model(input logic [3:0] o, input logic [63:0] a,
                                        input logic [63:0] b, input logic [31:0] s,
                                        input logic [1:0] k);
    logic [63:0] v = '0;
    logic [31:0] r = '0;
    case (o)
      4'd0, 4'd2, 4'd3:
        for (int i = 0; i < 8; i++) begin
          int x = int'(a[8*i +: 8]);
          int y = int'(b[8*i +: 8]);
          int z = (o == 4'd0) ? (x + y + 1) / 2 : (o == 4'd2) ? (x > y ? x : y) : (x < y ? x : y);
          v[8*i +: 8] = z[7:0];
        end
      4'd1:
        for (int i = 0; i < 4; i++) begin
          int x = int'(a[16*i +: 16]);
          int y = int'(b[16*i +: 16]);
          int z = (x + y + 1) / 2;
          v[16*i +: 16] = z[15:0];
        end
      4'd4, 4'd5:
        for (int i = 0; i < 4; i++) begin
          int x = int'($signed(a[16*i +: 16]));
          int y = int'($signed(b[16*i +: 16]));
          int z = (o == 4'd4) ? (x > y ? x : y) : (x < y ? x : y);
          v[16*i +: 16] = z[15:0];
        end
      4'd6: for (int i = 0; i < 8; i++) r[i] = a[8*i + 7];
      4'd7: r[15:0] = a[16*int'(k) +: 16];
      4'd8: begin v = a; v[16*int'(k) +: 16] = s[15:0]; end
      default: ;
    endcase
    return {r, v};
  endfunction

  task automatic apply(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                       input logic [31:0] s, input logic [1:0] k);
    logic [95:0] exp;
    @(posedge clk);
    op = o; opa = a; opb = b; sc = s; sel = k;
    exp = model(o, a, b, s, k);
    @(negedge clk);
    checks++;
    if ({sco, vec} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d: actual vec=%h sc=%h expected vec=%h sc=%h",
               tag(o), o, vec, sco, exp[63:0], exp[95:64]);
    end
    if (o == 4'd6 || o == 4'd7) begin
      checks++;
      if (vec !== 64'd0) begin
        errors++;
        $display("FAIL R8: actual vec=%h expected 0", vec);
      end
    end
  endtask

  initial begin
    rst_n = 0;
    op = 4'd15; opa = '0; opb = '0; sc = '0; sel = '0;
    repeat (2) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (vec !== '0 || sco !== '0) begin
      errors++;
      $display("FAIL R9 idle: actual vec=%h sc=%h expected 0", vec, sco);
    end
    apply(4'd0, {8{8'hFF}}, {8{8'hFF}}, 0, 0);                   // R1 overflow
    apply(4'd0, 64'h0001_0203_0405_0607, 64'h0000_0000_0000_0000, 0, 0); // R1 round up
    apply(4'd1, {4{16'hFFFF}}, {4{16'hFFFF}}, 0, 0);             // R2 overflow
    apply(4'd1, 64'h0003_0001_8000_7FFF, 64'h0000_0002_8001_0000, 0, 0); // R2
    apply(4'd2, 64'h80_7F_00_FF_01_FE_40_C0, 64'h7F_80_FF_00_FE_01_C0_40, 0, 0); // R3
    apply(4'd3, 64'h80_7F_00_FF_01_FE_40_C0, 64'h7F_80_FF_00_FE_01_C0_40, 0, 0); // R3
    apply(4'd4, 64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0001_FFFF, 0, 0); // R4 signed
    apply(4'd5, 64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0001_FFFF, 0, 0); // R4
    apply(4'd6, 64'h80_00_80_00_FF_7F_01_80, 0, 0, 0);           // R5
    for (int k = 0; k < 4; k++) begin
      apply(4'd7, 64'h4444_3333_2222_1111, 0, 32'hFFFF_FFFF, 2'(k));     // R6 each index
      apply(4'd8, 64'h4444_3333_2222_1111, 64'hDEAD_BEEF_DEAD_BEEF, 32'hABCD_9876, 2'(k)); // R7
    end
    for (int o = 9; o < 16; o++) apply(4'(o), {8{8'hA5}}, {8{8'h5A}}, 32'h1234_5678, 2'd3); // R9
    for (int n = 0; n < 3000; n++) begin                          // R8 mixed
      apply(4'($urandom_range(0, 15)), {$urandom, $urandom}, {$urandom, $urandom},
            $urandom, 2'($urandom_range(0, 3)));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule